// File: doc/BRIEF.md
# PPS-Disciplined Event Timestamp Capture

This block timestamps randomly spaced digital event pulses, such as those from a photon detector, against a local time base. The time base consists of a seconds count and a sub-second cycle count. An external once-per-second reference pulse restarts the sub-second count and advances the seconds count. The reference edge and the event edges are timed by the same counters, so any event time can be placed relative to the most recent reference edge.

Every detected rising edge becomes one capture record in an on-chip FIFO. The host does not take one interrupt per event. It takes a batch interrupt, either when the FIFO holds a programmable number of records or when a programmable timeout has run while the FIFO is not empty. It then drains a whole batch through a show-ahead read port. When the FIFO is full, new records are discarded and counted, and the records already stored are left intact.

Both inputs pass through a two-stage synchroniser and a rising-edge detector. A small capture state machine has two states. In state CAP_IDLE it writes at most one record per cycle: a reference record if a reference edge is present, otherwise an event record if an event edge is present. If both edges are detected in the same cycle, it writes the reference record and takes the transition CAP_IDLE to CAP_PEND. In state CAP_PEND it writes the held event record, which carries the same timestamp, and always returns to CAP_IDLE on the next cycle.

Top module: `pps_evt_stamp`

## Requirements
- R1: Each low-to-high transition of `evt_in` produces exactly one record with tag 0. Holding `evt_in` high or taking it low produces no record.
- R2: A record is 61 bits wide. Bit 60 is the tag (0 = event, 1 = reference), bits 59:28 hold the seconds count and bits 27:0 hold the sub-second count.
- R3: A reference edge advances the seconds count by one and restarts the sub-second count. An event whose edge is detected d cycles after a reference edge carries the new seconds value and a sub-second value of d-1. The reference record itself carries the seconds value from before the increment.
- R4: When a reference edge and an event edge are detected in the same cycle, the reference record is stored first and the event record second. Both carry identical seconds and sub-second values.
- R5: `holdover` goes high once the sub-second count reaches HOLD_CYC without a reference edge. The next reference edge takes it low again.
- R6: Records are read in the order they were written. `rd_valid` is high exactly when the FIFO is not empty, and `rd_en` with `rd_valid` high removes the head record.
- R7: With `thresh` non-zero, `batch_irq` is high whenever `fill_level` is at or above `thresh`. A value of 0 in `thresh` disables this condition.
- R8: With `tmo_cyc` = T non-zero, `batch_irq` rises exactly T cycles after the FIFO becomes non-empty. It falls when the FIFO is empty. A value of 0 in `tmo_cyc` disables this condition.
- R9: A record arriving at a full FIFO is dropped and the stored records are not changed. `overflow` is then set and stays set until reset, and `lost_count` increments by one for each dropped record.
- R10: `lost_count` saturates at its all-ones value.
- R11: After reset the FIFO is empty and `batch_irq`, `overflow`, `lost_count` and `holdover` are all zero.
- R12: Events spaced 4 cycles apart (2 high, 2 low) are all captured without loss while there is room. Their sub-second values differ by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pps_in | input | 1 | Asynchronous once-per-second reference pulse |
| evt_in | input | 1 | Asynchronous event pulse |
| thresh | input | LVL_W | Fill level that raises the batch interrupt, 0 = off |
| tmo_cyc | input | TMO_W | Cycles of non-empty FIFO before interrupt, 0 = off |
| rd_en | input | 1 | Pop the head record |
| rd_valid | output | 1 | FIFO not empty, head record on rd_data |
| rd_data | output | 61 | Head record (tag, seconds, sub-second) |
| fill_level | output | LVL_W | Number of stored records |
| batch_irq | output | 1 | Batch-ready interrupt |
| overflow | output | 1 | Sticky: a record was dropped |
| lost_count | output | LOST_W | Saturating count of dropped records |
| holdover | output | 1 | No reference edge within HOLD_CYC cycles |

## Verification
The two functions that can land in the same cycle are reference capture and event capture. The bench provokes this by raising `pps_in` and `evt_in` in the same time step, so both synchronisers report their edges in the same clock. It then judges the result by popping two records and requiring the reference record first, the event record second, and equal seconds and sub-second fields in both. The same collision is checked inside the design: an assertion requires the reference write and then the event write on the following cycle, and a second assertion requires that no new edge is seen while an event record is still held.

// File: rtl/pes_pkg.sv
package pes_pkg;
    localparam int SEC_W = 32;
    localparam int SUB_W = 28;
    localparam int REC_W = 1 + SEC_W + SUB_W;

    localparam logic TAG_EVT = 1'b0;
    localparam logic TAG_PPS = 1'b1;

    typedef struct packed {
        logic             tag;
        logic [SEC_W-1:0] sec;
        logic [SUB_W-1:0] sub;
    } rec_t;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_PEND = 1'b1
    } cap_st_e;
endpackage

// File: rtl/pes_edge_sync.sv
module pes_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/pes_timebase.sv
module pes_timebase
    import pes_pkg::*;
#(
    parameter int HOLD_CYC = 100_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_p,
    output logic [SEC_W-1:0] sec_q,
    output logic [SUB_W-1:0] sub_q,
    output logic             hold_q
);
    localparam logic [SUB_W-1:0] HOLD_M1 = SUB_W'(HOLD_CYC - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= '0;
            sub_q  <= '0;
            hold_q <= 1'b0;
        end else if (pps_p) begin
            sec_q  <= sec_q + 1'b1;
            sub_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            sub_q <= sub_q + 1'b1;
            if (sub_q >= HOLD_M1) begin
                hold_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pes_capture_fsm.sv
module pes_capture_fsm
    import pes_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pps_p,
    input  logic             evt_p,
    input  logic [SEC_W-1:0] sec,
    input  logic [SUB_W-1:0] sub,
    output logic             wr_en,
    output rec_t             wr_rec,
    output logic             pend
);
    cap_st_e          st_q, st_d;
    logic [SEC_W-1:0] held_sec;
    logic [SUB_W-1:0] held_sub;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAP_IDLE: st_d = (pps_p && evt_p) ? CAP_PEND : CAP_IDLE;
            CAP_PEND: st_d = CAP_IDLE;
            default:  st_d = CAP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CAP_IDLE;
            held_sec <= '0;
            held_sub <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == CAP_IDLE && pps_p && evt_p) begin
                held_sec <= sec;
                held_sub <= sub;
            end
        end
    end

    always_comb begin
        wr_en  = 1'b0;
        wr_rec = '{tag: TAG_EVT, sec: sec, sub: sub};
        unique case (st_q)
            CAP_IDLE: begin
                if (pps_p) begin
                    wr_en      = 1'b1;
                    wr_rec.tag = TAG_PPS;
                end else if (evt_p) begin
                    wr_en = 1'b1;
                end
            end
            CAP_PEND: begin
                wr_en  = 1'b1;
                wr_rec = '{tag: TAG_EVT, sec: held_sec, sub: held_sub};
            end
            default: wr_en = 1'b0;
        endcase
    end

    assign pend = (st_q == CAP_PEND);
endmodule

// File: rtl/pes_rec_fifo.sv
module pes_rec_fifo #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 61,
    parameter int LOST_W = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    output logic [WIDTH-1:0]  rd_data,
    output logic [LVL_W-1:0]  level,
    output logic              ovf_q,
    output logic [LOST_W-1:0] lost_q
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             push_ok, pop_ok;

    assign push_ok = wr_en && (level != FULL_LVL);
    assign pop_ok  = rd_en && (level != '0);
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr   <= '0;
            rptr   <= '0;
            level  <= '0;
            ovf_q  <= 1'b0;
            lost_q <= '0;
        end else begin
            if (push_ok) begin
                wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
            end
            if (pop_ok) begin
                rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
            end
            if (push_ok && !pop_ok) begin
                level <= level + 1'b1;
            end else if (pop_ok && !push_ok) begin
                level <= level - 1'b1;
            end
            if (wr_en && !push_ok) begin
                ovf_q <= 1'b1;
                if (lost_q != '1) begin
                    lost_q <= lost_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pps_evt_stamp.sv
module pps_evt_stamp
    import pes_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int HOLD_CYC = 100_000_000,
    parameter int TMO_W    = 16,
    parameter int LOST_W   = 16,
    localparam int LVL_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pps_in,
    input  logic              evt_in,
    input  logic [LVL_W-1:0]  thresh,
    input  logic [TMO_W-1:0]  tmo_cyc,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [REC_W-1:0]  rd_data,
    output logic [LVL_W-1:0]  fill_level,
    output logic              batch_irq,
    output logic              overflow,
    output logic [LOST_W-1:0] lost_count,
    output logic              holdover
);
    logic [1:0]       raw_in, rise;
    logic             pps_p, evt_p;
    logic [SEC_W-1:0] sec_q;
    logic [SUB_W-1:0] sub_q;
    logic             wr_en, wr_tag, cap_pend;
    rec_t             wr_rec;
    logic [TMO_W-1:0] to_cnt;
    logic             fifo_empty, thr_fire, to_fire;

    assign raw_in = {pps_in, evt_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        pes_edge_sync u_es (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[g]),
            .rise (rise[g])
        );
    end

    assign pps_p = rise[1];
    assign evt_p = rise[0];

    pes_timebase #(.HOLD_CYC(HOLD_CYC)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .pps_p (pps_p),
        .sec_q (sec_q),
        .sub_q (sub_q),
        .hold_q(holdover)
    );

    pes_capture_fsm u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .pps_p (pps_p),
        .evt_p (evt_p),
        .sec   (sec_q),
        .sub   (sub_q),
        .wr_en (wr_en),
        .wr_rec(wr_rec),
        .pend  (cap_pend)
    );

    assign wr_tag = wr_rec.tag;

    pes_rec_fifo #(.DEPTH(DEPTH), .WIDTH(REC_W), .LOST_W(LOST_W)) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_rec),
        .rd_en  (rd_en),
        .rd_data(rd_data),
        .level  (fill_level),
        .ovf_q  (overflow),
        .lost_q (lost_count)
    );

    assign fifo_empty = (fill_level == '0);
    assign rd_valid   = !fifo_empty;

    always_ff @(posedge clk) begin
        if (!rst_n || fifo_empty) begin
            to_cnt <= '0;
        end else if (to_cnt != '1) begin
            to_cnt <= to_cnt + 1'b1;
        end
    end

    assign thr_fire  = (thresh != '0) && (fill_level >= thresh);
    assign to_fire   = !fifo_empty && (tmo_cyc != '0) && (to_cnt >= tmo_cyc);
    assign batch_irq = thr_fire || to_fire;
endmodule

// File: rtl/pes_chk.sv
module pes_chk #(
    parameter int LVL_W  = 5,
    parameter int LOST_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pps_p,
    input logic              evt_p,
    input logic              cap_pend,
    input logic              wr_en,
    input logic              wr_tag,
    input logic [LVL_W-1:0]  fill_level,
    input logic [LVL_W-1:0]  thresh,
    input logic              batch_irq,
    input logic              overflow,
    input logic [LOST_W-1:0] lost_count,
    input logic              holdover
);
    p_pps_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_p && evt_p && !cap_pend) |-> (wr_en && wr_tag));

    p_evt_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pps_p && evt_p && !cap_pend) |=> (wr_en && !wr_tag && cap_pend));

    p_pend_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pend |-> (!pps_p && !evt_p));

    p_hold_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pps_p |=> !holdover);

    p_thr_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((thresh != '0) && (fill_level >= thresh)) |-> batch_irq);

    p_empty_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> !batch_irq);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    p_lost_mono_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lost_count >= $past(lost_count)));

    p_lost_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_count != '0) |-> overflow);
endmodule

bind pps_evt_stamp pes_chk #(.LVL_W(LVL_W), .LOST_W(LOST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pps_p     (pps_p),
    .evt_p     (evt_p),
    .cap_pend  (cap_pend),
    .wr_en     (wr_en),
    .wr_tag    (wr_tag),
    .fill_level(fill_level),
    .thresh    (thresh),
    .batch_irq (batch_irq),
    .overflow  (overflow),
    .lost_count(lost_count),
    .holdover  (holdover)
);

// File: tb/sim_pps_evt_stamp.sv
`timescale 1ns/1ps
module sim_pps_evt_stamp;
    localparam int DEPTH = 8;
    localparam int HOLD  = 200;
    localparam int TMO_W = 8;
    localparam int LOSTW = 3;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pps_in = 1'b0, evt_in = 1'b0, rd_en = 1'b0;
    logic [LVL_W-1:0]  thresh = '0;
    logic [TMO_W-1:0]  tmo_cyc = '0;
    logic              rd_valid, batch_irq, overflow, holdover;
    logic [60:0]       rd_data;
    logic [LVL_W-1:0]  fill_level;
    logic [LOSTW-1:0]  lost_count;

    int total = 0, bad = 0;
    bit done = 0;
    longint exp_sec = 0;

    always #2 clk = ~clk;

    pps_evt_stamp #(.DEPTH(DEPTH), .HOLD_CYC(HOLD), .TMO_W(TMO_W), .LOST_W(LOSTW)) u0 (
        .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .evt_in(evt_in),
        .thresh(thresh), .tmo_cyc(tmo_cyc), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .fill_level(fill_level), .batch_irq(batch_irq),
        .overflow(overflow), .lost_count(lost_count), .holdover(holdover)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic evt_pulse(input int hi, input int lo);
        evt_in = 1'b1;
        cyc(hi);
        evt_in = 1'b0;
        cyc(lo);
    endtask

    task automatic pop(output logic [60:0] r);
        @(negedge clk);
        chk(rd_valid == 1'b1, "R6 valid before pop", rd_valid, 1);
        r = rd_data;
        rd_en = 1'b1;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [60:0] r, r2;
        logic [27:0] base;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        @(negedge clk);
        // R11 reset state
        chk(rd_valid == 0 && fill_level == 0, "R11 empty", fill_level, 0);
        chk(batch_irq == 0, "R11 irq", batch_irq, 0);
        chk(overflow == 0 && lost_count == 0, "R11 ovf/lost", lost_count, 0);
        chk(holdover == 0, "R11 holdover", holdover, 0);
        cyc(1);

        // R1 R2 R3 R6: sweep event delay after reference edge
        for (int d = 3; d <= 10; d++) begin
            pps_in = 1'b1;
            cyc(2);
            pps_in = 1'b0;
            cyc(d - 2);
            evt_pulse(2, 8);
            pop(r);
            chk(r[60] == 1'b1, "R2 ref tag", r[60], 1);
            chk(r[59:28] == exp_sec, "R3 ref sec", r[59:28], exp_sec);
            exp_sec++;
            pop(r);
            chk(r[60] == 1'b0, "R1 evt tag", r[60], 0);
            chk(r[59:28] == exp_sec, "R3 evt sec", r[59:28], exp_sec);
            chk(r[27:0] == d - 1, "R3 evt sub", r[27:0], d - 1);
            cyc(2);
        end

        // R1 level held high / falling edge gives no extra record
        evt_in = 1'b1;
        cyc(20);
        @(negedge clk);
        chk(fill_level == 1, "R1 held high", fill_level, 1);
        cyc(1);
        evt_in = 1'b0;
        cyc(10);
        @(negedge clk);
        chk(fill_level == 1, "R1 falling edge", fill_level, 1);
        pop(r);
        cyc(2);

        // R4 coincident edges
        pps_in = 1'b1;
        evt_in = 1'b1;
        cyc(2);
        pps_in = 1'b0;
        evt_in = 1'b0;
        cyc(6);
        pop(r);
        pop(r2);
        chk(r[60] == 1'b1, "R4 ref first", r[60], 1);
        chk(r2[60] == 1'b0, "R4 evt second", r2[60], 0);
        chk(r[59:28] == exp_sec && r2[59:28] == exp_sec, "R4 sec", r2[59:28], exp_sec);
        chk(r[27:0] == r2[27:0], "R4 same sub", r2[27:0], r[27:0]);
        exp_sec++;
        cyc(2);

        // R12 burst at 4-cycle spacing
        for (int i = 0; i < DEPTH; i++) evt_pulse(2, 2);
        cyc(4);
        @(negedge clk);
        chk(fill_level == DEPTH, "R12 all stored", fill_level, DEPTH);
        chk(lost_count == 0, "R12 none lost", lost_count, 0);
        for (int i = 0; i < DEPTH; i++) begin
            pop(r);
            if (i == 0) base = r[27:0];
            chk(r[27:0] - base == 28'(4 * i), "R12 spacing", r[27:0] - base, 4 * i);
            chk(r[59:28] == exp_sec, "R12 sec", r[59:28], exp_sec);
        end
        cyc(2);

        // R7 threshold interrupt
        thresh = 3;
        evt_pulse(2, 2);
        evt_pulse(2, 6);
        @(negedge clk);
        chk(batch_irq == 0, "R7 below thresh", batch_irq, 0);
        cyc(1);
        evt_pulse(2, 6);
        @(negedge clk);
        chk(batch_irq == 1, "R7 at thresh", batch_irq, 1);
        pop(r);
        @(negedge clk);
        chk(batch_irq == 0, "R7 after pop", batch_irq, 0);
        pop(r);
        pop(r);
        thresh = 0;
        cyc(2);

        // R8 timeout interrupt
        tmo_cyc = 20;
        evt_in = 1'b1;
        for (int i = 0; i < 20 && !rd_valid; i++) begin
            @(negedge clk);
            if (i == 2) evt_in = 1'b0;
        end
        evt_in = 1'b0;
        repeat (19) @(negedge clk);
        chk(batch_irq == 0, "R8 before timeout", batch_irq, 0);
        @(negedge clk);
        chk(batch_irq == 1, "R8 at timeout", batch_irq, 1);
        pop(r);
        repeat (2) @(negedge clk);
        chk(batch_irq == 0 && rd_valid == 0, "R8 clears when empty", batch_irq, 0);
        tmo_cyc = 0;
        cyc(2);

        // R5 holdover
        pps_in = 1'b1;
        cyc(2);
        pps_in = 1'b0;
        exp_sec++;
        cyc(100);
        @(negedge clk);
        chk(holdover == 0, "R5 within window", holdover, 0);
        cyc(160);
        @(negedge clk);
        chk(holdover == 1, "R5 set", holdover, 1);
        cyc(1);
        pps_in = 1'b1;
        cyc(2);
        pps_in = 1'b0;
        exp_sec++;
        cyc(8);
        @(negedge clk);
        chk(holdover == 0, "R5 cleared", holdover, 0);
        while (rd_valid) pop(r);
        cyc(2);

        // R9 R10 overflow
        for (int i = 0; i < DEPTH; i++) evt_pulse(2, 2);
        cyc(4);
        @(negedge clk);
        chk(fill_level == DEPTH && overflow == 0, "R9 full no ovf", overflow, 0);
        cyc(1);
        for (int i = 0; i < 3; i++) evt_pulse(2, 2);
        cyc(4);
        @(negedge clk);
        chk(lost_count == 3, "R9 lost count", lost_count, 3);
        chk(overflow == 1, "R9 overflow set", overflow, 1);
        chk(fill_level == DEPTH, "R9 level kept", fill_level, DEPTH);
        cyc(1);
        for (int i = 0; i < 6; i++) evt_pulse(2, 2);
        cyc(4);
        @(negedge clk);
        chk(lost_count == 7, "R10 saturate", lost_count, 7);
        for (int i = 0; i < DEPTH; i++) begin
            pop(r);
            if (i == 0) base = r[27:0];
            chk(r[60] == 0 && r[27:0] - base == 28'(4 * i), "R9 contents kept", r[27:0] - base, 4 * i);
        end
        cyc(2);
        @(negedge clk);
        chk(overflow == 1 && rd_valid == 0, "R9 sticky", overflow, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule